// File: doc/BRIEF.md
# Hybrid Update/Invalidate Coherence Directory

This block is the directory controller for one bank of a shared memory cache. Coherence is kept through this directory and not by snooping the interconnect. For every line, the directory records which first-level caches hold a copy. Each request names a line, a source cache and whether it is a read miss or a write. Read misses only change the directory. A write produces coherence commands on a ready/valid output stream. The line data, the refill path and the network transport are outside the block.

Each entry keeps an exact list of sharer IDs with `THRESH` slots, and a copy count. While the count stays at or below `THRESH`, a write sends one targeted update to each listed sharer other than the writer. When a new sharer would push the count past `THRESH`, the entry spills. It then keeps only an overflow flag and a count, which saturates at its maximum. The next write to that line sends one broadcast invalidate. The entry is then rewritten so that the writer is its only sharer. Only one write's commands are outstanding at a time. No new request of any kind is accepted until the last command of that write has been taken.

Top module: `coh_dir`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0, and every line has no sharers and is not in overflow.
- R2: A read miss from a cache not yet recorded adds that cache as a sharer of the line.
- R3: A read miss from a cache already listed does not change the copy count. Repeated reads from one cache never make the line spill.
- R4: A write to a line not in overflow issues exactly one command with `cmd_bcast`=0 per listed sharer other than the writer. `cmd_dest` is the sharer ID and `cmd_line` is the written line.
- R5: No update command is addressed to the writing cache.
- R6: When recording a new sharer would make the count exceed `THRESH`, the line enters overflow. The next write to it issues exactly one command, with `cmd_bcast`=1, `cmd_dest` equal to the writer and `cmd_line` equal to the line.
- R7: After a broadcast, the line holds only the writer as a sharer and leaves overflow.
- R8: While any command of a write is unaccepted, `req_ready` is 0. A command held with `cmd_ready`=0 keeps `cmd_valid` and its payload stable.
- R9: Directory state of one line is not altered by requests to another line.
- R10: A write in list mode records the writer as a sharer, spilling into overflow if the list is full.
- R11: A read miss issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read miss |
| req_line | input | LW | Line index |
| req_src | input | IW | Requesting cache ID |
| cmd_valid | output | 1 | Coherence command present |
| cmd_ready | input | 1 | Command taken this cycle when high with `cmd_valid` |
| cmd_bcast | output | 1 | 1 = broadcast invalidate, 0 = targeted update |
| cmd_dest | output | IW | Target sharer, or the writer on a broadcast |
| cmd_line | output | LW | Line the command refers to |

## Verification
Every subset of four caches reads each of four lines, with threshold two, and is then written by each possible cache. This separates three cases: sets that stay in list mode and yield exact update sets, sets that spill and yield one broadcast, and writers that are or are not already sharers. Directed reads repeat one ID to show that duplicates do not cause a spill. A pseudo-random mix of reads and writes on all lines, under irregular `cmd_ready`, then shows three things: lines stay independent, state after a broadcast is correct, and the request side is blocked while commands drain.

// File: rtl/coh_dir.sv
module coh_dir #(
  parameter int NCACHE = 4,
  parameter int LINES  = 4,
  parameter int THRESH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [$clog2(LINES)-1:0]   req_line,
  input  logic [$clog2(NCACHE)-1:0]  req_src,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic                       cmd_bcast,
  output logic [$clog2(NCACHE)-1:0]  cmd_dest,
  output logic [$clog2(LINES)-1:0]   cmd_line
);
  localparam int IW = $clog2(NCACHE);
  localparam int LW = $clog2(LINES);
  localparam int CW = $clog2(NCACHE + 1) + 1;
  localparam int SW = (THRESH > 1) ? $clog2(THRESH) : 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [THRESH-1:0] vld [LINES];
  logic [IW-1:0]     sid [LINES][THRESH];
  logic              ovf [LINES];
  logic [CW-1:0]     cnt [LINES];

  logic [THRESH-1:0] pend;
  logic              pend_bc;
  logic [IW-1:0]     snap [THRESH];
  logic [IW-1:0]     bc_src;
  logic [LW-1:0]     cur_line;

  logic              busy, acc, hit, has_free;
  logic [THRESH-1:0] hitv;
  logic [SW-1:0]     free_slot, sel;

  assign busy      = (|pend) | pend_bc;
  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;

  always_comb begin
    hitv      = '0;
    has_free  = 1'b0;
    free_slot = '0;
    for (int k = THRESH - 1; k >= 0; k--) begin
      hitv[k] = vld[req_line][k] && (sid[req_line][k] == req_src);
      if (!vld[req_line][k]) begin
        has_free  = 1'b1;
        free_slot = SW'(k);
      end
    end
  end
  assign hit = |hitv;

  always_comb begin
    sel = '0;
    for (int k = THRESH - 1; k >= 0; k--)
      if (pend[k]) sel = SW'(k);
  end

  assign cmd_valid = busy;
  assign cmd_bcast = pend_bc;
  assign cmd_dest  = pend_bc ? bc_src : snap[sel];
  assign cmd_line  = cur_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_bc  <= 1'b0;
      bc_src   <= '0;
      cur_line <= '0;
      for (int l = 0; l < LINES; l++) begin
        vld[l] <= '0;
        ovf[l] <= 1'b0;
        cnt[l] <= '0;
        for (int k = 0; k < THRESH; k++) sid[l][k] <= '0;
      end
      for (int k = 0; k < THRESH; k++) snap[k] <= '0;
    end else if (acc) begin
      cur_line <= req_line;
      if (req_write && ovf[req_line]) begin
        pend_bc               <= 1'b1;
        bc_src                <= req_src;
        ovf[req_line]         <= 1'b0;
        cnt[req_line]         <= CW'(1);
        vld[req_line]         <= THRESH'(1);
        sid[req_line][0]      <= req_src;
      end else begin
        if (req_write) begin
          pend <= vld[req_line] & ~hitv;
          for (int k = 0; k < THRESH; k++) snap[k] <= sid[req_line][k];
        end
        if (ovf[req_line]) begin
          if (cnt[req_line] != CMAX) cnt[req_line] <= cnt[req_line] + 1'b1;
        end else if (!hit) begin
          cnt[req_line] <= cnt[req_line] + 1'b1;
          if (has_free) begin
            vld[req_line][free_slot] <= 1'b1;
            sid[req_line][free_slot] <= req_src;
          end else begin
            ovf[req_line] <= 1'b1;
            vld[req_line] <= '0;
          end
        end
      end
    end else if (busy && cmd_ready) begin
      if (pend_bc) pend_bc <= 1'b0;
      else         pend[sel] <= 1'b0;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_bcast) && $stable(cmd_dest) && $stable(cmd_line));
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
  a_r6_single_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_bcast |=> !cmd_valid);
  a_r11_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> !cmd_valid);
  a_r3_list_count: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf[req_line] |-> cnt[req_line] == CW'($countones(vld[req_line])));
  a_r7_after_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && ovf[req_line] |=> !ovf[cur_line] && cnt[cur_line] == CW'(1));
endmodule

// File: tb/coh_dir_bench.sv
module coh_dir_bench;
  localparam int  NCACHE = 4;
  localparam int  LINES  = 4;
  localparam int  THRESH = 2;
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, cmd_ready = 0;
  logic [1:0] req_line = 0, req_src = 0;
  logic req_ready, cmd_valid, cmd_bcast;
  logic [1:0] cmd_dest, cmd_line;

  coh_dir #(.NCACHE(NCACHE), .LINES(LINES), .THRESH(THRESH)) u_coh_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .req_src(req_src),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_bcast(cmd_bcast),
    .cmd_dest(cmd_dest), .cmd_line(cmd_line));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [NCACHE-1:0] mdl_set [LINES];
  bit                mdl_ovf [LINES];
  logic [NCACHE-1:0] got_mask;
  int  got_cnt, got_bc, got_badline, got_baddest, stall_bad;
  logic [1:0] exp_line;
  logic [7:0] rdy_lfsr = 8'h5a;

  always @(negedge clk) begin
    rdy_lfsr  = {rdy_lfsr[6:0], rdy_lfsr[7] ^ rdy_lfsr[5] ^ rdy_lfsr[4] ^ rdy_lfsr[3]};
    cmd_ready = rdy_lfsr[0] | rdy_lfsr[1];
    #1;
    if (cmd_valid && req_ready) stall_bad++;
    if (cmd_valid && cmd_ready) begin
      got_cnt++;
      if (cmd_line != exp_line) got_badline++;
      if (cmd_bcast) begin
        got_bc++;
        if (cmd_dest != req_src) got_baddest++;
      end else got_mask[cmd_dest] = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pop(input logic [NCACHE-1:0] v);
    int n = 0;
    for (int i = 0; i < NCACHE; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic req(input bit wr, input logic [1:0] line, input logic [1:0] src);
    logic [NCACHE-1:0] exp_mask;
    bit exp_bc;
    @(negedge clk);
    got_mask = 0; got_cnt = 0; got_bc = 0; got_badline = 0; got_baddest = 0; stall_bad = 0;
    exp_line = line;
    req_valid = 1; req_write = wr; req_line = line; req_src = src;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    req_valid = 0;
    do begin @(negedge clk); #2; end while (!(req_ready && !cmd_valid));
    @(negedge clk); #2;
    if (!wr) begin
      chk(got_cnt == 0, "R11 read issues no command", got_cnt, 0);
      if (!mdl_ovf[line]) begin
        mdl_set[line][src] = 1'b1;
        if (pop(mdl_set[line]) > THRESH) mdl_ovf[line] = 1;
      end
    end else begin
      exp_bc   = mdl_ovf[line];
      exp_mask = exp_bc ? '0 : (mdl_set[line] & ~(NCACHE'(1) << src));
      if (exp_bc) begin
        chk(got_cnt == 1 && got_bc == 1, "R6 one broadcast on overflowed line", got_cnt, 1);
        chk(got_baddest == 0, "R6 broadcast dest is writer", got_baddest, 0);
        mdl_set[line] = NCACHE'(1) << src;
        mdl_ovf[line] = 0;
      end else begin
        chk(got_bc == 0 && got_mask == exp_mask && got_cnt == pop(exp_mask),
            "R4 update set equals sharers minus writer", int'(got_mask), int'(exp_mask));
        chk(!got_mask[src], "R5 no update to writer", int'(got_mask[src]), 0);
        mdl_set[line][src] = 1'b1;
        if (pop(mdl_set[line]) > THRESH) mdl_ovf[line] = 1;
      end
      chk(got_badline == 0, "R9 command names written line", got_badline, 0);
      chk(stall_bad == 0, "R8 no request ready while commands pending", stall_bad, 0);
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rl;
    for (int l = 0; l < LINES; l++) begin mdl_set[l] = '0; mdl_ovf[l] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1 && cmd_valid == 0, "R1 reset outputs", int'({req_ready, cmd_valid}), 2);
    rst_n = 1;
    // R1: empty line gives an empty update set
    req(1, 2'd3, 2'd0);
    // R2 R3: repeated reads from one cache then a new one stay in list mode
    req(0, 2'd0, 2'd1); req(0, 2'd0, 2'd1); req(0, 2'd0, 2'd1); req(0, 2'd0, 2'd2);
    req(1, 2'd0, 2'd3);
    chk(got_bc == 0 && got_cnt == 2, "R3 duplicates not counted", got_cnt, 2);
    // R10: writer 3 joined, so the line spilled; R6 then R7
    req(1, 2'd0, 2'd0);
    chk(got_bc == 1, "R10 writer recorded caused spill", got_bc, 1);
    req(1, 2'd0, 2'd1);
    chk(got_mask == 4'b0001 && got_bc == 0, "R7 only writer after broadcast", int'(got_mask), 1);
    // exhaustive sweep of sharer subsets and writers on each line
    for (int l = 0; l < LINES; l++)
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < NCACHE; w++) begin
          for (int c = 0; c < NCACHE; c++) if (s[c]) req(0, 2'(l), 2'(c));
          req(1, 2'(l), 2'(w));
        end
    // mixed traffic over all lines
    rl = 8'h3c;
    for (int i = 0; i < 400; i++) begin
      rl = {rl[6:0], rl[7] ^ rl[5] ^ rl[4] ^ rl[3]};
      req(rl[0] & rl[6], rl[2:1], rl[4:3]);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule